// File: doc/BRIEF.md
# Hybrid Stochastic-Binary FIR Filter

This block is a small FIR filter in transposed form that forms every tap product on random bit streams and does every addition in two's-complement binary. A signed sample is presented together with a one-cycle valid strobe. The block then holds the sample for a conversion window of 2^STREAM_LOG clock cycles. In each cycle of that window, the sample and each fixed coefficient are compared against independent pseudo-random numbers, which gives one bit per stream. Each coefficient bit is combined with the sample bit by an XNOR gate. An up/down counter per tap turns the resulting product stream back into a signed binary count.

When the window closes, the counts enter a transposed delay-and-add chain. The chain gives one filtered word per accepted sample and signals it with a single-cycle strobe. Before encoding, the coefficients are multiplied by the largest power of two that keeps them inside the signed coefficient range. This uses the full span of the stochastic encoding and lowers the relative noise. The binary result is shifted right by the same power of two, so the overall gain does not depend on that scale.

A caller waits for `busy` to drop before presenting the next sample. The caller reads `out_data` when `out_valid` pulses.

Top module: `sfir_hybrid_filter`

## Requirements
- R1: A high `in_valid` in a cycle where `busy` is low is accepted at that clock edge. `busy` is high in the next cycle and stays high for exactly 2^STREAM_LOG cycles.
- R2: A high `in_valid` while `busy` is high is ignored. It neither lengthens the window nor changes any later output value.
- R3: `out_valid` is a single-cycle pulse. It is high in the cycle after the (2^STREAM_LOG+1)-th clock edge that follows the accepting edge, once for each accepted sample.
- R4: `out_data` changes only in the cycle in which `out_valid` is high, and holds its value otherwise.
- R5: Bipolar encoding is used. A signed DATA_W-bit sample v becomes the offset value v+2^(DATA_W-1), and a stream bit is 1 when a pseudo-random DATA_W-bit number is below that offset value. Coefficient k is the signed COEF_W-bit field at bits [k*COEF_W +: COEF_W] of `COEFFS`. For each output n, `out_data` approximates sum over k of c_k*x[n-k] * 2^STREAM_LOG / 2^(DATA_W+COEF_W-2). With the default configuration the error is within 160 LSB, for any sample amplitude.
- R6: Tap order follows the transposed chain: a lone nonzero sample followed by zeros reproduces c_0, c_1, ... c_{NTAPS-1} on successive outputs.
- R7: Reset clears the partial-sum registers. The first output after reset reflects only the newest sample times c_0.
- R8: During and directly after reset, `busy` and `out_valid` are low and `out_data` is zero.
- R9: No partial sum or output overflows. `out_data` stays within ±NTAPS*2^STREAM_LOG, and full-scale alternating samples that line up with the coefficient signs give the correct large result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe, taken only while not busy |
| in_data | input | DATA_W | Signed two's-complement sample |
| busy | output | 1 | High while a conversion window runs |
| out_valid | output | 1 | One-cycle strobe for a new filtered word |
| out_data | output | STREAM_LOG+2+clog2(NTAPS) | Signed filtered output, rescaled |

## Verification
`busy` is due in the cycle after the accepting edge and falls after the 2^STREAM_LOG-th edge. The new output word and its strobe are due one edge after that. The bench counts rising edges from the accepting edge and samples every output at the falling edge between them. It checks `busy` on the last in-window edge and on the first edge after the window, and checks the strobe and the word on exactly the (2^STREAM_LOG+1)-th edge. Because the products carry stream noise, the bench derives output values from a binary model of the delay line with a fixed tolerance, while every timing check is exact.

// File: rtl/sfir_pkg.sv
// Shared constants, control state type and seed helper for the hybrid
// stochastic FIR filter. Assumes 16-bit Galois generators.
package sfir_pkg;

    localparam int              RNG_W    = 16;
    localparam logic [RNG_W-1:0] RNG_POLY = 16'hB400;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } ctl_state_t;

    // Distinct nonzero seed per stream index, spread across the sequence.
    function automatic logic [RNG_W-1:0] sfir_seed(input int idx);
        logic [RNG_W-1:0] s;
        s = RNG_W'(32'hACE1 + 32'(idx) * 32'h2F47);
        return (s == '0) ? {{(RNG_W-1){1'b0}}, 1'b1} : s;
    endfunction

endpackage

// File: rtl/sfir_lfsr.sv
// Free pseudo-random source: Galois LFSR that advances only when enabled.
// Exposes the top OUT_W state bits as a uniform random number.
// Assumes SEED is nonzero and POLY is a maximal-length polynomial.
module sfir_lfsr #(
    parameter int                  STATE_W = 16,
    parameter logic [STATE_W-1:0]  POLY    = 16'hB400,
    parameter logic [STATE_W-1:0]  SEED    = 16'hACE1,
    parameter int                  OUT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [OUT_W-1:0] rnd
);

    logic [STATE_W-1:0] state;

    // Advance the shift register once per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (en) begin
            state <= {1'b0, state[STATE_W-1:1]} ^ (state[0] ? POLY : '0);
        end
    end

    assign rnd = state[STATE_W-1 -: OUT_W];

endmodule

// File: rtl/sfir_sng.sv
// Bipolar stream bit generator: converts a signed value to offset binary and
// emits 1 when the random number is below it, so P(1) = (v + 2^(W-1)) / 2^W.
// Purely combinational.
module sfir_sng #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] rnd,
    output logic         bit_o
);

    logic [W-1:0] offset;

    // Flip the sign bit to move from two's complement to offset binary.
    always_comb begin
        offset = {~value[W-1], value[W-2:0]};
        bit_o  = (rnd < offset);
    end

endmodule

// File: rtl/sfir_tap.sv
// One filter tap: own coefficient stream, XNOR product with the shared
// sample stream, and an up/down counter recovering the product.
// Assumes COEF is already scaled; clear and en are never high together.
module sfir_tap #(
    parameter int                 COEF_W     = 8,
    parameter int                 STREAM_LOG = 10,
    parameter logic [COEF_W-1:0]  COEF       = '0,
    parameter logic [15:0]        SEED       = 16'h1D2B
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         en,
    input  logic                         x_bit,
    output logic signed [STREAM_LOG+1:0] prod
);

    localparam int                 ACC_W = STREAM_LOG + 2;
    localparam logic signed [ACC_W-1:0] ONE = 1;

    logic [COEF_W-1:0] rnd;
    logic              c_bit;
    logic              p_bit;

    sfir_lfsr #(
        .STATE_W (sfir_pkg::RNG_W),
        .POLY    (sfir_pkg::RNG_POLY),
        .SEED    (SEED),
        .OUT_W   (COEF_W)
    ) coef_rng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .rnd   (rnd)
    );

    sfir_sng #(.W(COEF_W)) coef_sng_i (
        .value (COEF),
        .rnd   (rnd),
        .bit_o (c_bit)
    );

    // Bipolar multiply: XNOR of the two streams.
    assign p_bit = ~(x_bit ^ c_bit);

    // Count ones up and zeros down over the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prod <= '0;
        end else if (en) begin
            prod <= p_bit ? prod + ONE : prod - ONE;
        end
    end

endmodule

// File: rtl/sfir_hybrid_filter.sv
// Transposed FIR filter with stochastic tap products and binary accumulation.
// Accepts a sample when idle, runs a 2^STREAM_LOG-cycle conversion, then
// shifts the recovered products through the partial-sum chain.
// Assumes NTAPS >= 2 and coefficients packed LSB-first in COEFFS.
module sfir_hybrid_filter
    import sfir_pkg::*;
#(
    parameter int                        DATA_W     = 8,
    parameter int                        COEF_W     = 8,
    parameter int                        NTAPS      = 4,
    parameter int                        STREAM_LOG = 10,
    parameter logic [NTAPS*COEF_W-1:0]   COEFFS     = 32'hC90FE232
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          in_valid,
    input  logic signed [DATA_W-1:0]                      in_data,
    output logic                                          busy,
    output logic                                          out_valid,
    output logic signed [STREAM_LOG+1+$clog2(NTAPS):0]    out_data
);

    localparam int PROD_W = STREAM_LOG + 2;
    localparam int SUM_W  = PROD_W + $clog2(NTAPS);
    localparam int CMAX   = (1 << (COEF_W - 1)) - 1;
    localparam logic [STREAM_LOG-1:0] PH_ONE = 1;

    // Largest power-of-two shift keeping every coefficient in range.
    function automatic int scale_shift();
        int mx;
        int s;
        mx = 0;
        for (int k = 0; k < NTAPS; k++) begin
            int c;
            c = int'($signed(COEFFS[k*COEF_W +: COEF_W]));
            if (c < 0) c = -c;
            if (c > mx) mx = c;
        end
        s = 0;
        for (int i = 0; i < COEF_W - 1; i++) begin
            if (mx != 0 && (mx << (s + 1)) <= CMAX) s = s + 1;
        end
        return s;
    endfunction

    localparam int SHIFT = scale_shift();

    ctl_state_t               state;
    logic [STREAM_LOG-1:0]    phase;
    logic [DATA_W-1:0]        sample;
    logic                     accept;
    logic                     run;
    logic                     last;
    logic [DATA_W-1:0]        smp_rnd;
    logic                     x_bit;
    logic signed [PROD_W-1:0] prod [NTAPS];
    logic signed [SUM_W-1:0]  psum [NTAPS-1];

    assign run    = (state == ST_RUN);
    assign accept = in_valid && !run;
    assign last   = (phase == '1);
    assign busy   = run;

    // Sequence idle, stream window and chain-update phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (in_valid) state <= ST_RUN;
                ST_RUN:  if (last)     state <= ST_DONE;
                default: state <= in_valid ? ST_RUN : ST_IDLE;
            endcase
        end
    end

    // Capture the sample and count the window cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            sample <= '0;
        end else if (accept) begin
            phase  <= '0;
            sample <= in_data;
        end else if (run) begin
            phase  <= phase + PH_ONE;
        end
    end

    sfir_lfsr #(
        .STATE_W (RNG_W),
        .POLY    (RNG_POLY),
        .SEED    (sfir_seed(0)),
        .OUT_W   (DATA_W)
    ) smp_rng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .rnd   (smp_rnd)
    );

    sfir_sng #(.W(DATA_W)) smp_sng_i (
        .value (sample),
        .rnd   (smp_rnd),
        .bit_o (x_bit)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        localparam logic [COEF_W-1:0] CK =
            COEF_W'(COEFFS[k*COEF_W +: COEF_W] << SHIFT);
        sfir_tap #(
            .COEF_W     (COEF_W),
            .STREAM_LOG (STREAM_LOG),
            .COEF       (CK),
            .SEED       (sfir_seed(k + 1))
        ) tap_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (accept),
            .en    (run),
            .x_bit (x_bit),
            .prod  (prod[k])
        );
    end

    // Transposed delay-and-add update, output rescale and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            for (int k = 0; k < NTAPS - 1; k++) psum[k] <= '0;
        end else begin
            out_valid <= (state == ST_DONE);
            if (state == ST_DONE) begin
                out_data <= (SUM_W'(prod[0]) + psum[0]) >>> SHIFT;
                for (int k = 0; k < NTAPS - 2; k++) begin
                    psum[k] <= SUM_W'(prod[k+1]) + psum[k+1];
                end
                psum[NTAPS-2] <= SUM_W'(prod[NTAPS-1]);
            end
        end
    end

endmodule

// File: rtl/sfir_hybrid_filter_chk.sv
// Protocol and range checker for the hybrid filter, bound to its top.
// Tracks the busy run length with its own counter.
module sfir_hybrid_filter_chk #(
    parameter int STREAM_LOG = 10,
    parameter int NTAPS      = 4,
    parameter int OUT_W      = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    busy,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);

    localparam logic [STREAM_LOG:0] LAST  = (1 << STREAM_LOG) - 1;
    localparam int                  BOUND = NTAPS << STREAM_LOG;
    localparam logic [STREAM_LOG:0] C_ONE = 1;

    logic [STREAM_LOG:0] run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + C_ONE;
        else           run_len <= '0;
    end

    AST_ACCEPT:        assert property (@(posedge clk) disable iff (!rst_n)
                           !busy && in_valid |=> busy);                         // R1
    AST_BUSY_LEN:      assert property (@(posedge clk) disable iff (!rst_n)
                           busy |-> run_len <= LAST);                           // R1
    AST_NO_RESTART:    assert property (@(posedge clk) disable iff (!rst_n)
                           $fell(busy) |-> $past(run_len) == LAST);             // R2
    AST_VALID_DUE:     assert property (@(posedge clk) disable iff (!rst_n)
                           $fell(busy) |=> out_valid);                          // R3
    AST_VALID_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
                           out_valid |=> !out_valid);                           // R3
    AST_OUT_HOLD:      assert property (@(posedge clk) disable iff (!rst_n)
                           !$rose(out_valid) |-> $stable(out_data));            // R4
    AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (!rst_n)
                           (int'(out_data) <= BOUND) && (int'(out_data) >= -BOUND)); // R9

endmodule

bind sfir_hybrid_filter sfir_hybrid_filter_chk #(
    .STREAM_LOG (STREAM_LOG),
    .NTAPS      (NTAPS),
    .OUT_W      (STREAM_LOG + 2 + $clog2(NTAPS))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sfir_hybrid_filter_tb.sv
module sfir_hybrid_filter_tb_top;

    localparam int DATA_W = 8;
    localparam int COEF_W = 8;
    localparam int NTAPS  = 4;
    localparam int SL     = 10;
    localparam logic [NTAPS*COEF_W-1:0] CF = 32'hC90FE232;
    localparam int OUT_W  = SL + 2 + $clog2(NTAPS);
    localparam int WIN    = 1 << SL;
    localparam int TOL    = 160;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic                     busy;
    logic                     out_valid;
    logic signed [OUT_W-1:0]  out_data;

    int vectors = 0;
    int miss    = 0;
    int hist [NTAPS];

    always #2.5 clk = ~clk;

    sfir_hybrid_filter #(
        .DATA_W (DATA_W), .COEF_W (COEF_W), .NTAPS (NTAPS),
        .STREAM_LOG (SL), .COEFFS (CF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .busy (busy), .out_valid (out_valid), .out_data (out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int coef(input int k);
        return int'($signed(CF[k*COEF_W +: COEF_W]));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8", int'(busy), 0);
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        chk(out_data == '0, "R8", int'(out_data), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NTAPS; k++) hist[k] = 0;
        @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0 && out_data == '0, "R8", int'(out_data), 0);
    endtask

    task automatic send(input int x, input bit inject, input string vtag);
        int  n;
        int  y0;
        bit  seen;
        bit  held;
        int  acc;
        real er;
        real d;
        @(negedge clk);
        while (busy) @(negedge clk);
        in_valid = 1'b1;
        in_data  = DATA_W'(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy == 1'b1, "R1", int'(busy), 1);
        for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        acc = 0;
        for (int k = 0; k < NTAPS; k++) acc += coef(k) * hist[k];
        er = real'(acc) * (2.0 ** SL) / (2.0 ** (DATA_W + COEF_W - 2));
        y0 = int'(out_data);
        n = 0; seen = 0; held = 1;
        while (!seen && n < 3 * WIN) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 100) begin
                in_valid = 1'b1;
                in_data  = DATA_W'(-x - 1);
            end
            if (inject && n == 101) in_valid = 1'b0;
            if (n == WIN - 1) chk(busy == 1'b1, inject ? "R2" : "R1", int'(busy), 1);
            if (n == WIN)     chk(busy == 1'b0, inject ? "R2" : "R1", int'(busy), 0);
            if (out_valid) seen = 1;
            else if (int'(out_data) != y0) held = 0;
        end
        chk(n == WIN + 1, "R3", n, WIN + 1);
        chk(held, "R4", int'(out_data), y0);
        d = real'(int'(out_data)) - er;
        if (d < 0.0) d = -d;
        chk(d <= real'(TOL), vtag, int'(out_data), int'(er));
        @(negedge clk);
        chk(out_valid == 1'b0, "R3", int'(out_valid), 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        miss++;
        vectors++;
        $display("FAIL R3 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        do_reset();
        // R6: impulse responses of both signs walk the taps in order
        send(127, 0, "R6");
        for (int i = 0; i < NTAPS; i++) send(0, 0, "R6");
        send(-128, 0, "R6");
        for (int i = 0; i < NTAPS; i++) send(0, 0, "R6");
        // R2: a strobe during the window must leave timing and values alone
        send(100, 1, "R2");
        for (int i = 0; i < NTAPS; i++) send(0, 0, "R2");
        // R5: amplitude sweep across the signed range
        for (int v = -128; v <= 127; v += 32) send(v, 0, "R5");
        send(127, 0, "R5");
        // R9: sign pattern matching the coefficients gives full-scale sums
        for (int i = 0; i < 6; i++) send((i % 2 == 0) ? -128 : 127, 0, "R9");
        // R7: reset in mid-stream clears the partial sums
        do_reset();
        send(127, 0, "R7");
        send(0, 0, "R7");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

endmodule